// File: doc/BRIEF.md
# Beat-Frequency Phase Meter

This block measures the phase offset between two clocks of the same nominal frequency. A third clock, whose frequency is close to but not equal to theirs, drives the whole block. On every edge of this offset clock each measured clock is captured by a flip-flop. The captured values form two slow square waves whose frequency is the difference between the two clock rates. Because the beat is slow, a tiny phase offset between the inputs becomes a long run of offset-clock cycles between the two beat edges. This magnification is what makes the measurement precise.

Each beat wave first crosses a two-flop synchroniser. A deglitching state machine then cleans it. The machine accepts the first transition it sees and ignores the input for a hold-off of several cycles, because the slow sweep and input jitter make the beat edges chatter. A free-running timestamp counter is tagged on each clean rising edge. A pairing state machine subtracts the reference (A) tag from the next B tag, which gives the phase. It subtracts successive A tags, which gives the beat period. It presents both values with a one-cycle strobe. Software scales the counts to time units. The offset clock is generated elsewhere and arrives as `clk_smp`.

Deglitcher states:
- `DG_LOW`: clean level low, watching for a rise.
- `DG_HOLD_HI`: hold-off after an accepted rise.
- `DG_HIGH`: clean level high, watching for a fall.
- `DG_HOLD_LO`: hold-off after an accepted fall.

Deglitcher transitions:
- accept-rise: `DG_LOW` to `DG_HOLD_HI`.
- settle-high: `DG_HOLD_HI` to `DG_HIGH`, when the hold-off count expires.
- accept-fall: `DG_HIGH` to `DG_HOLD_LO`.
- settle-low: `DG_HOLD_LO` to `DG_LOW`, when the hold-off count expires.

Pairing states:
- `PF_IDLE`: no A edge seen since reset.
- `PF_PRIME`: one A edge seen, so no period is known yet.
- `PF_WAIT_B`: an A tag is held and a B edge is awaited.
- `PF_WAIT_A`: a result has been issued and the next A edge is awaited.

Pairing transitions:
- first-A: `PF_IDLE` to `PF_PRIME`.
- second-A: `PF_PRIME` to `PF_WAIT_B`.
- B-hit: `PF_WAIT_B` to `PF_WAIT_A`, which issues a result.
- next-A: `PF_WAIT_A` to `PF_WAIT_B`.
- re-arm: an A edge while in `PF_WAIT_B` stays in `PF_WAIT_B` with fresh tags.
- coincident: A and B in the same cycle, from any state but `PF_IDLE`, go to `PF_WAIT_A` and issue phase 0.

Top module: `beat_phase_meter`

## Requirements
- R1: While reset is held and right after it is released, `vld_o` is 0 and `phase_o` and `period_o` are 0.
- R2: `phase_o` equals the number of sampling cycles from a clean rising edge of beat A to the next clean rising edge of beat B.
- R3: `period_o` equals the number of sampling cycles between the two most recent clean rising edges of beat A. It is updated in the same cycle as the result that follows those edges.
- R4: No result is issued before two A rising edges have been seen. B edges that occur before the second A edge are ignored.
- R5: `vld_o` is high for exactly one cycle per result. Only the first B rising edge after an A rising edge produces a result, and further B edges before the next A edge are ignored.
- R6: After an accepted transition, the deglitcher ignores the input for the hold-off count of cycles. The edge is timed at the first transition, so chatter inside the hold-off changes neither the phase nor the period.
- R7: `holdoff_i` sets the hold-off in sampling cycles, and the value 0 selects the default of 16. A transition that arrives after the hold-off has expired is accepted as a new edge.
- R8: When the A and B rising edges are detected in the same cycle, after the first A edge, a result with phase 0 is issued.
- R9: If a second A rising edge arrives before any B edge, the A tag and the period are updated and the block keeps waiting for B. The next B is measured from the newest A edge.
- R10: The tags come from a free-running counter of `TS_W` bits, and differences are taken modulo 2^`TS_W`. Results stay correct across counter wrap as long as the beat period is below 2^`TS_W` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_smp | input | 1 | Offset sampling clock; every register uses it |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_a_i | input | 1 | Reference clock A, sampled as data |
| clk_b_i | input | 1 | Measured clock B, sampled as data |
| holdoff_i | input | HOLD_W | Deglitch hold-off in cycles; 0 selects the default |
| vld_o | output | 1 | One-cycle result strobe |
| phase_o | output | TS_W | Cycles from the A edge to the B edge |
| period_o | output | TS_W | Cycles between the last two A edges |

## Verification
The bench drives beat waves with known edge spacings and adds chatter inside the hold-off window. A deglitcher that retimes on a late transition would shift the reported phase. The bench also places a second B pulse inside a single beat period, and a design that paired it would produce two strobes per period. It tests coincident A and B edges, B edges that arrive only every other A period, and a short hold-off that lets a deliberate A re-rise through. A design that mishandled re-arming would report a stale period. One run crosses several counter wraps with a phase close to the full period, which catches subtraction done without the modular wrap.

// File: rtl/bpm_pkg.sv
package bpm_pkg;

    typedef enum logic [1:0] {
        DG_LOW     = 2'd0,
        DG_HOLD_HI = 2'd1,
        DG_HIGH    = 2'd2,
        DG_HOLD_LO = 2'd3
    } dg_state_t;

    typedef enum logic [1:0] {
        PF_IDLE   = 2'd0,
        PF_PRIME  = 2'd1,
        PF_WAIT_B = 2'd2,
        PF_WAIT_A = 2'd3
    } pf_state_t;

    localparam int NUM_CH = 2;
    localparam int CH_A   = 0;
    localparam int CH_B   = 1;

endpackage

// File: rtl/bpm_capture.sv
module bpm_capture #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_smp,
    input  logic rst_n,
    input  logic sig_i,
    output logic beat_o
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    // stage 0 is the mixing flop, the rest form the synchroniser
    always_ff @(posedge clk_smp) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= sig_i;
    end

    genvar gi;
    generate
        for (gi = 1; gi < CHAIN; gi++) begin : g_sync
            always_ff @(posedge clk_smp) begin
                if (!rst_n) chain_q[gi] <= 1'b0;
                else        chain_q[gi] <= chain_q[gi-1];
            end
        end
    endgenerate

    assign beat_o = chain_q[CHAIN-1];

endmodule

// File: rtl/bpm_deglitch.sv
module bpm_deglitch
    import bpm_pkg::*;
#(
    parameter int HOLD_W   = 8,
    parameter int HOLD_DEF = 16
) (
    input  logic              clk_smp,
    input  logic              rst_n,
    input  logic              beat_i,
    input  logic [HOLD_W-1:0] holdoff_i,
    output logic              rise_o,
    output logic              level_o
);
    localparam logic [HOLD_W-1:0] DEF_CNT = HOLD_W'(HOLD_DEF);

    dg_state_t         state_q, state_n;
    logic [HOLD_W-1:0] cnt_q;
    logic [HOLD_W-1:0] hold_eff;
    logic              expired;

    assign hold_eff = (holdoff_i == '0) ? DEF_CNT : holdoff_i;
    assign expired  = (cnt_q <= HOLD_W'(1));

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            DG_LOW:     if (beat_i)  state_n = DG_HOLD_HI;
            DG_HOLD_HI: if (expired) state_n = DG_HIGH;
            DG_HIGH:    if (!beat_i) state_n = DG_HOLD_LO;
            DG_HOLD_LO: if (expired) state_n = DG_LOW;
            default:                 state_n = DG_LOW;
        endcase
    end

    // state register and hold-off counter
    always_ff @(posedge clk_smp) begin
        if (!rst_n) begin
            state_q <= DG_LOW;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            if ((state_q == DG_LOW && beat_i) || (state_q == DG_HIGH && !beat_i))
                cnt_q <= hold_eff;
            else if (!expired)
                cnt_q <= cnt_q - HOLD_W'(1);
        end
    end

    // registered outputs
    always_ff @(posedge clk_smp) begin
        if (!rst_n) begin
            rise_o  <= 1'b0;
            level_o <= 1'b0;
        end else begin
            rise_o <= (state_q == DG_LOW) && beat_i;
            unique case (state_n)
                DG_HOLD_HI, DG_HIGH: level_o <= 1'b1;
                default:             level_o <= 1'b0;
            endcase
        end
    end

    AST_DG_RISE_LEVEL: assert property (@(posedge clk_smp) disable iff (!rst_n)
        rise_o |-> level_o);                                          // R6
    AST_DG_HOLD_QUIET: assert property (@(posedge clk_smp) disable iff (!rst_n)
        rise_o |=> !rise_o);                                          // R6

endmodule

// File: rtl/bpm_pair.sv
module bpm_pair
    import bpm_pkg::*;
#(
    parameter int TS_W = 24
) (
    input  logic            clk_smp,
    input  logic            rst_n,
    input  logic            rise_a_i,
    input  logic            rise_b_i,
    output logic            vld_o,
    output logic [TS_W-1:0] phase_o,
    output logic [TS_W-1:0] period_o
);
    pf_state_t       state_q, state_n;
    logic [TS_W-1:0] ts_q;
    logic [TS_W-1:0] tag_a_q;
    logic            both;

    assign both = rise_a_i && rise_b_i;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            PF_IDLE:   if (rise_a_i) state_n = PF_PRIME;
            PF_PRIME:  if (rise_a_i) state_n = both ? PF_WAIT_A : PF_WAIT_B;
            PF_WAIT_B: begin
                if (rise_a_i)      state_n = both ? PF_WAIT_A : PF_WAIT_B;
                else if (rise_b_i) state_n = PF_WAIT_A;
            end
            PF_WAIT_A: if (rise_a_i) state_n = both ? PF_WAIT_A : PF_WAIT_B;
            default:                 state_n = PF_IDLE;
        endcase
    end

    // state register and free-running timestamp
    always_ff @(posedge clk_smp) begin
        if (!rst_n) begin
            state_q <= PF_IDLE;
            ts_q    <= '0;
        end else begin
            state_q <= state_n;
            ts_q    <= ts_q + TS_W'(1);
        end
    end

    // tags and results
    always_ff @(posedge clk_smp) begin
        if (!rst_n) begin
            tag_a_q  <= '0;
            vld_o    <= 1'b0;
            phase_o  <= '0;
            period_o <= '0;
        end else begin
            vld_o <= 1'b0;
            if (rise_a_i) begin
                tag_a_q <= ts_q;
                if (state_q != PF_IDLE) period_o <= ts_q - tag_a_q;
            end
            if (state_q != PF_IDLE && both) begin
                phase_o <= '0;
                vld_o   <= 1'b1;
            end else if (state_q == PF_WAIT_B && rise_b_i && !rise_a_i) begin
                phase_o <= ts_q - tag_a_q;
                vld_o   <= 1'b1;
            end
        end
    end

    AST_VLD_SINGLE: assert property (@(posedge clk_smp) disable iff (!rst_n)
        vld_o |=> !vld_o);                                            // R5
    AST_NO_EARLY_RESULT: assert property (@(posedge clk_smp) disable iff (!rst_n)
        (state_q == PF_IDLE) |=> !vld_o);                             // R4
    AST_PERIOD_KNOWN: assert property (@(posedge clk_smp) disable iff (!rst_n)
        vld_o |-> (period_o != '0));                                  // R3
    AST_WAIT_A_NO_B: assert property (@(posedge clk_smp) disable iff (!rst_n)
        (state_q == PF_WAIT_A && rise_b_i && !rise_a_i) |=> !vld_o);  // R5

endmodule

// File: rtl/beat_phase_meter.sv
module beat_phase_meter
    import bpm_pkg::*;
#(
    parameter int TS_W        = 24,
    parameter int HOLD_W      = 8,
    parameter int HOLD_DEF    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_smp,
    input  logic              rst_n,
    input  logic              clk_a_i,
    input  logic              clk_b_i,
    input  logic [HOLD_W-1:0] holdoff_i,
    output logic              vld_o,
    output logic [TS_W-1:0]   phase_o,
    output logic [TS_W-1:0]   period_o
);
    logic [NUM_CH-1:0] raw_in;
    logic [NUM_CH-1:0] beat;
    logic [NUM_CH-1:0] rise;
    logic [NUM_CH-1:0] level;

    assign raw_in[CH_A] = clk_a_i;
    assign raw_in[CH_B] = clk_b_i;

    genvar ch;
    generate
        for (ch = 0; ch < NUM_CH; ch++) begin : g_chan
            bpm_capture #(.SYNC_STAGES(SYNC_STAGES)) cap_i (
                .clk_smp (clk_smp),
                .rst_n   (rst_n),
                .sig_i   (raw_in[ch]),
                .beat_o  (beat[ch])
            );
            bpm_deglitch #(.HOLD_W(HOLD_W), .HOLD_DEF(HOLD_DEF)) dg_i (
                .clk_smp   (clk_smp),
                .rst_n     (rst_n),
                .beat_i    (beat[ch]),
                .holdoff_i (holdoff_i),
                .rise_o    (rise[ch]),
                .level_o   (level[ch])
            );
        end
    endgenerate

    bpm_pair #(.TS_W(TS_W)) pair_i (
        .clk_smp  (clk_smp),
        .rst_n    (rst_n),
        .rise_a_i (rise[CH_A]),
        .rise_b_i (rise[CH_B]),
        .vld_o    (vld_o),
        .phase_o  (phase_o),
        .period_o (period_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk_smp)
        !rst_n |=> !vld_o);                                           // R1
    AST_RISE_NEEDS_LEVEL: assert property (@(posedge clk_smp) disable iff (!rst_n)
        $onehot0({rise[CH_A] && !level[CH_A], rise[CH_B] && !level[CH_B]}) &&
        !(rise[CH_A] && !level[CH_A]));                               // R6

endmodule

// File: tb/beat_phase_meter_tb_top.sv
module beat_phase_meter_tb_top;
    localparam int TS_W   = 10;
    localparam int HOLD_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clk_a = 1'b0;
    logic              clk_b = 1'b0;
    logic [HOLD_W-1:0] holdoff = '0;
    logic              vld;
    logic [TS_W-1:0]   phase;
    logic [TS_W-1:0]   period;

    always #2.5 clk = ~clk;

    beat_phase_meter #(.TS_W(TS_W), .HOLD_W(HOLD_W)) dut_i (
        .clk_smp   (clk),
        .rst_n     (rst_n),
        .clk_a_i   (clk_a),
        .clk_b_i   (clk_b),
        .holdoff_i (holdoff),
        .vld_o     (vld),
        .phase_o   (phase),
        .period_o  (period)
    );

    // beat wave configuration: offset, period, high time, forced-low window
    int a_off, a_per, a_hi, a_gs, a_ge;
    int b_off, b_per, b_hi, b_gs, b_ge;
    int cyc;
    int exp_phase, exp_period;
    int n_vld, n_bad, n_dbl, bad_ph, bad_pr;
    logic prev_vld;
    int n_checks = 0;
    int n_fail = 0;

    function automatic logic lvl(int c, int off, int per, int hi, int gs, int ge);
        int r;
        if (c < off) return 1'b0;
        r = (c - off) % per;
        return (r < hi) && !(r >= gs && r < ge);
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            cyc   <= 0;
            clk_a <= 1'b0;
            clk_b <= 1'b0;
        end else begin
            cyc   <= cyc + 1;
            clk_a <= lvl(cyc, a_off, a_per, a_hi, a_gs, a_ge);
            clk_b <= lvl(cyc, b_off, b_per, b_hi, b_gs, b_ge);
        end
    end

    // result monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            n_vld <= 0; n_bad <= 0; n_dbl <= 0; prev_vld <= 1'b0;
            bad_ph <= 0; bad_pr <= 0;
        end else begin
            prev_vld <= vld;
            if (vld) begin
                n_vld <= n_vld + 1;
                if (prev_vld) n_dbl <= n_dbl + 1;
                if (int'(phase) != exp_phase || int'(period) != exp_period) begin
                    n_bad  <= n_bad + 1;
                    bad_ph <= int'(phase);
                    bad_pr <= int'(period);
                end
            end
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic cfg(input int ao, input int ap, input int ah, input int ags, input int age,
                       input int bo, input int bp, input int bh, input int bgs, input int bge,
                       input int hold, input int eph, input int epr);
        a_off = ao; a_per = ap; a_hi = ah; a_gs = ags; a_ge = age;
        b_off = bo; b_per = bp; b_hi = bh; b_gs = bgs; b_ge = bge;
        holdoff = HOLD_W'(hold);
        exp_phase = eph; exp_period = epr;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_and_check(input int cycles, input int exp_cnt, input string req);
        repeat (cycles) @(negedge clk);
        chk(n_vld == exp_cnt, req, n_vld, exp_cnt);
        chk(n_bad == 0, req, bad_ph, exp_phase);
        chk(n_bad == 0, req, bad_pr, exp_period);
        chk(n_dbl == 0, "R5", n_dbl, 0);
    endtask

    task automatic t_reset();
        cfg(0, 200, 100, 0, 0, 37, 200, 100, 0, 0, 0, 37, 200);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(vld == 1'b0, "R1", int'(vld), 0);
        chk(phase == '0 && period == '0, "R1", int'(phase) + int'(period), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(vld == 1'b0 && phase == '0 && period == '0, "R1", int'(vld), 0);
    endtask

    task automatic t_basic();
        cfg(0, 200, 100, 0, 0, 37, 200, 100, 0, 0, 0, 37, 200);
        do_reset();
        repeat (150) @(negedge clk);
        chk(n_vld == 0, "R4", n_vld, 0);                 // B before second A ignored
        run_and_check(1850, 9, "R2 R3");
    endtask

    task automatic t_extra_b();
        // B falls at 20 and rises again at 60 within one period: R5
        cfg(0, 200, 100, 0, 0, 37, 200, 100, 20, 60, 0, 37, 200);
        do_reset();
        run_and_check(2000, 9, "R5");
    endtask

    task automatic t_glitch();
        // chatter inside default hold-off on both waves: R6
        cfg(0, 200, 100, 2, 6, 37, 200, 100, 3, 5, 0, 37, 200);
        do_reset();
        run_and_check(2000, 9, "R6");
    endtask

    task automatic t_holdoff_short();
        // A low from 6 to 16 after rising; hold-off 4 lets re-rise at 16 through: R7 R9
        cfg(0, 200, 100, 6, 16, 37, 200, 100, 0, 0, 4, 21, 16);
        do_reset();
        run_and_check(2000, 10, "R7 R9");
    endtask

    task automatic t_holdoff_default();
        // same A wave with hold-off 0 (default 16): dip is swallowed: R7
        cfg(0, 200, 100, 6, 16, 37, 200, 100, 0, 0, 0, 37, 200);
        do_reset();
        run_and_check(2000, 9, "R7");
    endtask

    task automatic t_coincident();
        cfg(0, 200, 100, 0, 0, 0, 200, 100, 0, 0, 0, 0, 200);
        do_reset();
        run_and_check(2000, 9, "R8");
    endtask

    task automatic t_missing_b();
        // B rises only every other A period: R9
        cfg(0, 200, 100, 0, 0, 37, 400, 200, 0, 0, 0, 37, 200);
        do_reset();
        run_and_check(2400, 5, "R9");
    endtask

    task automatic t_wrap();
        // 10-bit tags wrap about three times over this run: R10
        cfg(0, 300, 150, 0, 0, 250, 300, 150, 0, 0, 0, 250, 300);
        do_reset();
        run_and_check(3050, 9, "R10");
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_basic();
                t_extra_b();
                t_glitch();
                t_holdoff_short();
                t_holdoff_default();
                t_coincident();
                t_missing_b();
                t_wrap();
            end
            begin
                repeat (100000) @(negedge clk);
                chk(1'b0, "watchdog", 0, 1);
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule